// File: doc/BRIEF.md
# Coverage-Class Timing Parameter Generator

This block turns a few channel settings into the three timing values that a wireless MAC's interframe logic needs. It takes the bandwidth mode, the band, an 11b-channel flag with its short-slot enable, and an 8-bit coverage class. From these it produces the effective slot time, the ACK timeout and the CTS timeout in microseconds. It also gives each timeout as a count of core clock ticks.

Each timeout is converted to ticks by multiplying it by a clocks-per-microsecond parameter. The result is then checked against the width of its tick field. A value that does not fit is refused: the stored timeout keeps its old value, and an error pulse is raised. All outputs are registered and change only in the cycle after a load strobe.

Top module: `ccls_timing_gen`

## Requirements
- R1: While `rst` is high and after it falls, before any load, every output is zero.
- R2: The base slot time follows `bw_mode`. The encodings are: 0 standard, 1 double-width (40 MHz) → 6 µs, 2 half-rate (10 MHz) → 13 µs, 3 quarter-rate (5 MHz) → 21 µs. The standard mode gives 9 µs.
- R3: In standard mode, when `chan_11b` is 1 and `short_slot_en` is 0, the base slot time is 20 µs. When `short_slot_en` is 1 it stays 9 µs.
- R4: SIFS follows the same mode encoding: double-width 8 µs, half-rate 32 µs, quarter-rate 64 µs. In standard mode it is 16 µs when `band_5g` is 1, and 10 µs otherwise.
- R5: `slot_us` equals the base slot time plus 3 × `cov_class`.
- R6: The ACK timeout in µs equals SIFS plus `slot_us`. The CTS timeout equals the ACK timeout.
- R7: Each tick output equals its µs value multiplied by 40 (the default clocks per µs).
- R8: When a timeout's tick count exceeds 16383, the largest value a 14-bit field holds, that timeout's µs and tick outputs keep their previous values. `slot_us` still updates.
- R9: `cfg_err` is high for exactly the one cycle after a load in which a timeout was refused. Otherwise it is low.
- R10: Outputs change only on the clock edge where `load` is high. Input changes without `load` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Strobe that captures a new parameter set |
| bw_mode | input | 2 | Bandwidth mode (0 std, 1 double, 2 half, 3 quarter) |
| band_5g | input | 1 | 1 selects the 5 GHz band |
| chan_11b | input | 1 | 1 marks an 11b channel |
| short_slot_en | input | 1 | 1 allows the short slot on 11b channels |
| cov_class | input | 8 | Coverage class |
| slot_us | output | 12 | Effective slot time, µs |
| ack_us | output | 12 | ACK timeout, µs |
| cts_us | output | 12 | CTS timeout, µs |
| ack_ticks | output | 14 | ACK timeout, clock ticks |
| cts_ticks | output | 14 | CTS timeout, clock ticks |
| cfg_err | output | 1 | One-cycle pulse when a timeout was refused |

## Verification
The bench sweeps all four bandwidth modes with coverage class zero, which separates the per-mode slot and SIFS choices. Standard mode is then run on both bands and with the 11b flag set, with and without short slot. This tells the band selection apart from the long-slot override. Non-zero coverage classes show the 3 µs step. A coverage class of 130 lands just inside the 14-bit tick field and 131 lands just outside, which pins the refusal to the exact boundary. A load-free input change confirms that outputs hold.

// File: rtl/ccls_pkg.sv
package ccls_pkg;
  typedef enum logic [1:0] {
    BW_STD = 2'd0,
    BW_DBL = 2'd1,
    BW_HALF = 2'd2,
    BW_QTR = 2'd3
  } bw_mode_e;
endpackage

// File: rtl/ccls_base_sel.sv
module ccls_base_sel #(
  parameter int US_W = 12,
  parameter int SLOT_STD = 9,
  parameter int SLOT_11B = 20,
  parameter int SLOT_DBL = 6,
  parameter int SLOT_HALF = 13,
  parameter int SLOT_QTR = 21,
  parameter int SIFS_BG = 10,
  parameter int SIFS_5G = 16,
  parameter int SIFS_DBL = 8,
  parameter int SIFS_HALF = 32,
  parameter int SIFS_QTR = 64
) (
  input  ccls_pkg::bw_mode_e bw,
  input  logic               band_5g,
  input  logic               chan_11b,
  input  logic               short_slot_en,
  output logic [US_W-1:0]    base_slot,
  output logic [US_W-1:0]    sifs
);
  import ccls_pkg::*;

  always_comb begin
    unique case (bw)
      BW_DBL: begin
        base_slot = US_W'(SLOT_DBL);
        sifs      = US_W'(SIFS_DBL);
      end
      BW_HALF: begin
        base_slot = US_W'(SLOT_HALF);
        sifs      = US_W'(SIFS_HALF);
      end
      BW_QTR: begin
        base_slot = US_W'(SLOT_QTR);
        sifs      = US_W'(SIFS_QTR);
      end
      default: begin
        base_slot = (chan_11b && !short_slot_en) ? US_W'(SLOT_11B) : US_W'(SLOT_STD);
        sifs      = band_5g ? US_W'(SIFS_5G) : US_W'(SIFS_BG);
      end
    endcase
  end
endmodule

// File: rtl/ccls_tick_conv.sv
module ccls_tick_conv #(
  parameter int US_W = 12,
  parameter int CLK_PER_US = 40,
  parameter int FIELD_W = 14
) (
  input  logic [US_W-1:0]    us_val,
  output logic [FIELD_W-1:0] ticks,
  output logic               fits
);
  localparam int PROD_W = US_W + $clog2(CLK_PER_US + 1);
  localparam logic [PROD_W-1:0] FIELD_MAX = PROD_W'((64'd1 << FIELD_W) - 64'd1);

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod  = PROD_W'(us_val) * PROD_W'(CLK_PER_US);
    fits  = (prod <= FIELD_MAX);
    ticks = prod[FIELD_W-1:0];
  end
endmodule

// File: rtl/ccls_timing_gen.sv
module ccls_timing_gen #(
  parameter int US_W = 12,
  parameter int COV_W = 8,
  parameter int CLK_PER_US = 40,
  parameter int ACK_W = 14,
  parameter int CTS_W = 14,
  parameter int COV_STEP = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [1:0]       bw_mode,
  input  logic             band_5g,
  input  logic             chan_11b,
  input  logic             short_slot_en,
  input  logic [COV_W-1:0] cov_class,
  output logic [US_W-1:0]  slot_us,
  output logic [US_W-1:0]  ack_us,
  output logic [US_W-1:0]  cts_us,
  output logic [ACK_W-1:0] ack_ticks,
  output logic [CTS_W-1:0] cts_ticks,
  output logic             cfg_err
);
  import ccls_pkg::*;

  localparam int PROD_W = US_W + $clog2(CLK_PER_US + 1);

  bw_mode_e         bw;
  logic [US_W-1:0]  base_slot, sifs, eff_slot, tout_us;
  logic [ACK_W-1:0] ack_tk_n;
  logic [CTS_W-1:0] cts_tk_n;
  logic             ack_fit, cts_fit;

  assign bw = bw_mode_e'(bw_mode);

  ccls_base_sel #(.US_W(US_W)) u_sel (
    .bw(bw), .band_5g(band_5g), .chan_11b(chan_11b),
    .short_slot_en(short_slot_en), .base_slot(base_slot), .sifs(sifs)
  );

  always_comb begin
    eff_slot = base_slot + US_W'(cov_class) * US_W'(COV_STEP);
    tout_us  = sifs + eff_slot;
  end

  ccls_tick_conv #(.US_W(US_W), .CLK_PER_US(CLK_PER_US), .FIELD_W(ACK_W)) u_ack_conv (
    .us_val(tout_us), .ticks(ack_tk_n), .fits(ack_fit)
  );

  ccls_tick_conv #(.US_W(US_W), .CLK_PER_US(CLK_PER_US), .FIELD_W(CTS_W)) u_cts_conv (
    .us_val(tout_us), .ticks(cts_tk_n), .fits(cts_fit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_us   <= '0;
      ack_us    <= '0;
      cts_us    <= '0;
      ack_ticks <= '0;
      cts_ticks <= '0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_err <= 1'b0;
      if (load) begin
        slot_us <= eff_slot;
        if (ack_fit) begin
          ack_us    <= tout_us;
          ack_ticks <= ack_tk_n;
        end
        if (cts_fit) begin
          cts_us    <= tout_us;
          cts_ticks <= cts_tk_n;
        end
        cfg_err <= !(ack_fit && cts_fit);
      end
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(slot_us) && $stable(ack_us) && $stable(cts_us)
               && $stable(ack_ticks) && $stable(cts_ticks)));

  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(load));

  // R8
  keep_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !ack_fit) |=> ($stable(ack_us) && $stable(ack_ticks)));

  // R7
  tick_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (PROD_W'(ack_us) * PROD_W'(CLK_PER_US)) == PROD_W'(ack_ticks));

  generate
    if (ACK_W == CTS_W) begin : g_same_w
      // R6
      cts_eq_chk: assert property (@(posedge clk) disable iff (rst)
        cts_us == ack_us && cts_ticks == ack_ticks);
    end
  endgenerate
endmodule

// File: tb/sim_ccls_timing_gen.sv
`timescale 1ns/1ps
module sim_ccls_timing_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        load;
  logic [1:0]  bw_mode;
  logic        band_5g, chan_11b, short_slot_en;
  logic [7:0]  cov_class;
  logic [11:0] slot_us, ack_us, cts_us;
  logic [13:0] ack_ticks, cts_ticks;
  logic        cfg_err;

  int total = 0;
  int bad = 0;
  int e_slot = 0, e_ack = 0, e_tk = 0;

  always #4 clk = ~clk;

  ccls_timing_gen u0 (
    .clk(clk), .rst(rst), .load(load), .bw_mode(bw_mode), .band_5g(band_5g),
    .chan_11b(chan_11b), .short_slot_en(short_slot_en), .cov_class(cov_class),
    .slot_us(slot_us), .ack_us(ack_us), .cts_us(cts_us),
    .ack_ticks(ack_ticks), .cts_ticks(cts_ticks), .cfg_err(cfg_err)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_slot(int bw, bit b11, bit ss);
    case (bw)
      1: return 6;
      2: return 13;
      3: return 21;
      default: return (b11 && !ss) ? 20 : 9;
    endcase
  endfunction

  function automatic int m_sifs(int bw, bit b5);
    case (bw)
      1: return 8;
      2: return 32;
      3: return 64;
      default: return b5 ? 16 : 10;
    endcase
  endfunction

  task automatic apply(string req, int bw, bit b5, bit b11, bit ss, int cov);
    int s, a, t;
    bit rej;
    s = m_slot(bw, b11, ss) + 3 * cov;
    a = m_sifs(bw, b5) + s;
    t = a * 40;
    rej = (t > 16383);
    e_slot = s;
    if (!rej) begin
      e_ack = a;
      e_tk = t;
    end
    @(negedge clk);
    bw_mode = 2'(bw); band_5g = b5; chan_11b = b11; short_slot_en = ss;
    cov_class = 8'(cov); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk({req, " slot"}, int'(slot_us), e_slot);
    chk({req, " ack_us"}, int'(ack_us), e_ack);
    chk({req, " cts_us"}, int'(cts_us), e_ack);
    chk({req, " ack_ticks"}, int'(ack_ticks), e_tk);
    chk({req, " cts_ticks"}, int'(cts_ticks), e_tk);
    chk({req, " err"}, int'(cfg_err), int'(rej));
  endtask

  task automatic t_reset();
    // R1
    chk("R1 slot", int'(slot_us), 0);
    chk("R1 ack", int'(ack_us), 0);
    chk("R1 cts", int'(cts_us), 0);
    chk("R1 ticks", int'(ack_ticks) + int'(cts_ticks), 0);
    chk("R1 err", int'(cfg_err), 0);
  endtask

  task automatic t_modes();
    apply("R2 R4 R6 R7 std", 0, 0, 0, 0, 0);
    apply("R2 R4 dbl", 1, 0, 0, 0, 0);
    apply("R2 R4 half", 2, 0, 0, 0, 0);
    apply("R2 R4 qtr", 3, 1, 1, 0, 0);
  endtask

  task automatic t_long_slot();
    apply("R3 long", 0, 0, 1, 0, 0);
    apply("R3 short", 0, 0, 1, 1, 0);
  endtask

  task automatic t_band();
    apply("R4 5g", 0, 1, 0, 0, 0);
  endtask

  task automatic t_coverage();
    apply("R5 cov10", 0, 0, 0, 0, 10);
    apply("R5 cov7 half", 2, 0, 0, 0, 7);
  endtask

  task automatic t_overflow();
    apply("R8 edge fit", 0, 0, 0, 0, 130);
    apply("R8 R9 over", 0, 0, 0, 0, 131);
    @(negedge clk);
    chk("R9 pulse end", int'(cfg_err), 0);
    chk("R8 kept ack", int'(ack_us), 409);
    apply("R8 R9 qtr max", 3, 0, 0, 0, 255);
    apply("R9 recover", 0, 0, 0, 0, 1);
  endtask

  task automatic t_hold();
    // R10
    @(negedge clk);
    bw_mode = 2'd3; cov_class = 8'd200; band_5g = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 slot", int'(slot_us), e_slot);
    chk("R10 ack", int'(ack_us), e_ack);
    chk("R10 ticks", int'(ack_ticks), e_tk);
    chk("R10 err", int'(cfg_err), 0);
  endtask

  initial begin
    rst = 1'b1; load = 1'b0; bw_mode = 2'd0; band_5g = 1'b0;
    chan_11b = 1'b0; short_slot_en = 1'b0; cov_class = 8'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_modes();
    t_long_slot();
    t_band();
    t_coverage();
    t_overflow();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule